// File: doc/BRIEF.md
# Snooping Three-State Coherence Controller

This block tracks the coherence state of every tracked line in a small group of private caches attached to one snooping bus. Each core presents a read or write request carrying a byte address. The line is found by dropping the low six address bits, because the coherence unit is 64 bytes. An arbiter grants one request per cycle, rotating among the requesting cores. The block then updates its per-core, per-line state table and, one cycle later, reports the result. The report says whether the access was served locally or needed a bus transaction, gives the requester's new state, and lists which other caches must invalidate or downgrade their copy.

The protocol has three states: Exclusive (the only valid copy anywhere), Read-only (valid, possibly shared) and Invalid (stale). There is no dirty state, and data movement is not modelled. A probe port reads back the state of one line in every cache, so that the single-owner invariant can be checked from outside.

Top module: `coh_tracker`

## Requirements
- R1: After reset every line in every cache is Invalid, `grant` is zero and `rsp_valid` is low until a request is granted.
- R2: States are encoded Invalid = 2'b00, Read-only = 2'b01, Exclusive = 2'b10. `probe_state[2j+1:2j]` gives the state in cache j of the line whose index is `probe_line`. A request's line index is byte-address bits [6 +: LINE_BITS]. Addresses that differ only in bits [5:0] name the same line, and bits above the index are not used.
- R3: A read to a line that is Read-only or Exclusive in the requesting cache is a hit. It changes no state and raises no `inval` or `downgrade` bit.
- R4: A read to a line that is Invalid in the requester, while no other cache holds a valid copy, is a miss and leaves the requester Exclusive.
- R5: A read miss while another cache holds a valid copy leaves the requester Read-only. Any cache that held the line Exclusive becomes Read-only, and its `downgrade` bit is set.
- R6: A write to a line not Exclusive in the requester is a miss. Every other cache holding a valid copy goes to Invalid with its `inval` bit set, and the requester becomes Exclusive.
- R7: A write to a line already Exclusive in the requester is a hit, with no state change elsewhere and no `inval` or `downgrade` bit.
- R8: At most one `grant` bit is high per cycle, and only for a core whose `req_valid` is high. The search starts at the core after the last one granted (core 0 first after reset), so simultaneous requests are served round-robin.
- R9: One cycle after a grant, `rsp_valid` is high for exactly one cycle. `rsp_core` gives the granted core, `rsp_hit` is 1 for a local hit, and `rsp_state` is the requester's new state. `inval` and `downgrade` never include the requester.
- R10: For every line, at most one cache holds it Exclusive, and an Exclusive copy never coexists with a Read-only copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORE | Request pending per core, held until granted |
| req_write | input | NCORE | 1 = write, 0 = read, per core |
| req_addr | input | NCORE*ADDR_W | Byte address per core, core j at bits [j*ADDR_W +: ADDR_W] |
| grant | output | NCORE | One-hot grant, same cycle as the request |
| rsp_valid | output | 1 | Result of last cycle's grant is valid |
| rsp_core | output | CORE_W | Index of the granted core |
| rsp_hit | output | 1 | Served locally, no bus transaction |
| rsp_state | output | 2 | Requester's new state for the line |
| inval | output | NCORE | Caches told to invalidate the line |
| downgrade | output | NCORE | Caches told to drop Exclusive to Read-only |
| probe_line | input | LINE_BITS | Line index to observe |
| probe_state | output | 2*NCORE | State of the probed line in each cache |

## Verification
The checker module checks on every cycle that grants are one-hot and only go to requesters, and that each grant yields exactly one response in the next cycle. It also checks that hits raise no snoop signal, that the requester is never snooped, that every access leaves the requester valid, and that the single-owner invariant holds for whatever line is probed. Only the bench scenarios can show that the chosen state is right for each read and write case. The same goes for the rotation order of the arbiter, for addresses that alias through their low six bits, and for the table matching an independent model after every transaction.

// File: rtl/coh_tracker.sv
module coh_tracker #(
  parameter int NCORE     = 4,
  parameter int LINE_BITS = 4,
  parameter int ADDR_W    = 32,
  parameter int CORE_W    = $clog2(NCORE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCORE-1:0]        req_valid,
  input  logic [NCORE-1:0]        req_write,
  input  logic [NCORE*ADDR_W-1:0] req_addr,
  output logic [NCORE-1:0]        grant,
  output logic                    rsp_valid,
  output logic [CORE_W-1:0]       rsp_core,
  output logic                    rsp_hit,
  output logic [1:0]              rsp_state,
  output logic [NCORE-1:0]        inval,
  output logic [NCORE-1:0]        downgrade,
  input  logic [LINE_BITS-1:0]    probe_line,
  output logic [2*NCORE-1:0]      probe_state
);
  localparam int OFS   = 6;
  localparam int NLINE = 1 << LINE_BITS;
  localparam logic [1:0] S_INV = 2'd0, S_RO = 2'd1, S_EX = 2'd2;

  logic [1:0]           st [NCORE][NLINE];
  logic [1:0]           nxt [NCORE];
  logic [CORE_W-1:0]    last, gidx;
  logic [LINE_BITS-1:0] gline;
  logic                 found, gwr, others, hit;
  logic [1:0]           own;
  logic [NCORE-1:0]     inv_v, dn_v;
  logic                 unused_addr_bits;

  assign unused_addr_bits = ^req_addr;

  always_comb begin
    grant = '0;
    gidx  = last;
    found = 1'b0;
    for (int k = 1; k <= NCORE; k++) begin
      int idx;
      idx = (int'(last) + k) % NCORE;
      if (!found && req_valid[idx]) begin
        found = 1'b1;
        gidx  = CORE_W'(idx);
      end
    end
    if (found) grant[gidx] = 1'b1;
  end

  assign gline = req_addr[int'(gidx)*ADDR_W + OFS +: LINE_BITS];
  assign gwr   = req_write[gidx];
  assign own   = st[gidx][gline];
  assign hit   = gwr ? (own == S_EX) : (own != S_INV);

  always_comb begin
    others = 1'b0;
    for (int j = 0; j < NCORE; j++)
      if (j != int'(gidx) && st[j][gline] != S_INV) others = 1'b1;
  end

  always_comb begin
    for (int j = 0; j < NCORE; j++) begin
      nxt[j]   = st[j][gline];
      inv_v[j] = 1'b0;
      dn_v[j]  = 1'b0;
      if (!hit) begin
        if (j == int'(gidx)) begin
          nxt[j] = (gwr || !others) ? S_EX : S_RO;
        end else if (gwr) begin
          if (st[j][gline] != S_INV) begin
            nxt[j]   = S_INV;
            inv_v[j] = 1'b1;
          end
        end else if (st[j][gline] == S_EX) begin
          nxt[j]  = S_RO;
          dn_v[j] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < NCORE; j++)
        for (int l = 0; l < NLINE; l++)
          st[j][l] <= S_INV;
      last      <= CORE_W'(NCORE - 1);
      rsp_valid <= 1'b0;
      rsp_core  <= '0;
      rsp_hit   <= 1'b0;
      rsp_state <= S_INV;
      inval     <= '0;
      downgrade <= '0;
    end else begin
      rsp_valid <= found;
      inval     <= found ? inv_v : '0;
      downgrade <= found ? dn_v : '0;
      if (found) begin
        last      <= gidx;
        rsp_core  <= gidx;
        rsp_hit   <= hit;
        rsp_state <= nxt[gidx];
        for (int j = 0; j < NCORE; j++)
          st[j][gline] <= nxt[j];
      end
    end
  end

  always_comb
    for (int j = 0; j < NCORE; j++)
      probe_state[2*j +: 2] = st[j][probe_line];

endmodule

// File: rtl/coh_tracker_chk.sv
module coh_tracker_chk #(
  parameter int NCORE  = 4,
  parameter int CORE_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCORE-1:0]   req_valid,
  input logic [NCORE-1:0]   grant,
  input logic               rsp_valid,
  input logic [CORE_W-1:0]  rsp_core,
  input logic               rsp_hit,
  input logic [1:0]         rsp_state,
  input logic [NCORE-1:0]   inval,
  input logic [NCORE-1:0]   downgrade,
  input logic [2*NCORE-1:0] probe_state
);
  int n_ex, n_ro;
  always_comb begin
    n_ex = 0;
    n_ro = 0;
    for (int j = 0; j < NCORE; j++) begin
      if (probe_state[2*j +: 2] == 2'd2) n_ex++;
      if (probe_state[2*j +: 2] == 2'd1) n_ro++;
    end
  end

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R8
  grant_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_valid) == '0);
  // R9
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> rsp_valid);
  // R9
  rsp_only_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|grant) |=> !rsp_valid);
  // R3
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (inval == '0 && downgrade == '0));
  // R9
  self_not_snooped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!inval[rsp_core] && !downgrade[rsp_core]));
  // R6
  requester_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_state == 2'd1 || rsp_state == 2'd2));
  // R10
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_ex <= 1) && (n_ex == 0 || n_ro == 0));
endmodule

bind coh_tracker coh_tracker_chk #(.NCORE(NCORE), .CORE_W(CORE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .grant(grant),
  .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_hit(rsp_hit),
  .rsp_state(rsp_state), .inval(inval), .downgrade(downgrade),
  .probe_state(probe_state));

// File: tb/sim_coh_tracker.sv
module sim_coh_tracker;
  localparam int NC = 4, LB = 4, AW = 32, CW = 2;
  localparam int NL = 1 << LB;

  logic clk = 0, rst_n = 0;
  logic [NC-1:0] req_valid = '0, req_write = '0;
  logic [NC*AW-1:0] req_addr = '0;
  logic [NC-1:0] grant, inval, downgrade;
  logic rsp_valid, rsp_hit;
  logic [CW-1:0] rsp_core;
  logic [1:0] rsp_state;
  logic [LB-1:0] probe_line = '0;
  logic [2*NC-1:0] probe_state;

  coh_tracker #(.NCORE(NC), .LINE_BITS(LB), .ADDR_W(AW)) u0 (.*);

  always #4 clk = ~clk;

  typedef struct {
    int core; bit hit; logic [1:0] st; logic [NC-1:0] inv, dn;
    int line; logic [2*NC-1:0] col;
  } item_t;

  item_t exp_q[$];
  int gorder[$];
  logic [1:0] mst [NC][NL];
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic item_t model(int c, bit w, int line);
    item_t it; bit oth = 0;
    for (int j = 0; j < NC; j++) if (j != c && mst[j][line] != 0) oth = 1;
    it.core = c; it.line = line; it.inv = '0; it.dn = '0;
    it.hit = w ? (mst[c][line] == 2) : (mst[c][line] != 0);
    if (!it.hit) begin
      for (int j = 0; j < NC; j++) begin
        if (j == c) mst[j][line] = (w || !oth) ? 2'd2 : 2'd1;
        else if (w && mst[j][line] != 0) begin mst[j][line] = 0; it.inv[j] = 1; end
        else if (!w && mst[j][line] == 2) begin mst[j][line] = 1; it.dn[j] = 1; end
      end
    end
    it.st = mst[c][line];
    for (int j = 0; j < NC; j++) it.col[2*j +: 2] = mst[j][line];
    return it;
  endfunction

  task automatic access(int c, bit w, logic [31:0] a);
    @(negedge clk);
    req_valid[c] = 1; req_write[c] = w; req_addr[c*AW +: AW] = a;
    forever begin
      #1;
      if (grant[c]) break;
      @(negedge clk);
    end
    gorder.push_back(c);
    exp_q.push_back(model(c, w, int'(a[6 +: LB])));
    @(posedge clk);
    #1 req_valid[c] = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R9", "unexpected rsp", 1, 0);
      else begin
        item_t e; int ex, ro;
        e = exp_q.pop_front();
        chk(int'(rsp_core) == e.core, "R8", "rsp_core", rsp_core, e.core);
        chk(rsp_hit == e.hit, e.hit ? "R3/R7" : "R4/R6", "rsp_hit", rsp_hit, e.hit);
        chk(rsp_state == e.st, "R5", "rsp_state", rsp_state, e.st);
        chk(inval == e.inv, "R6", "inval", inval, e.inv);
        chk(downgrade == e.dn, "R5", "downgrade", downgrade, e.dn);
        probe_line = e.line[LB-1:0];
        #1;
        chk(probe_state == e.col, "R2", "probe column", probe_state, e.col);
        ex = 0; ro = 0;
        for (int j = 0; j < NC; j++) begin
          if (probe_state[2*j +: 2] == 2) ex++;
          if (probe_state[2*j +: 2] == 1) ro++;
        end
        chk(ex <= 1 && (ex == 0 || ro == 0), "R10", "owners", ex, ro);
      end
    end
  end

  task automatic chk_order(int a, int b);
    int x, y;
    x = gorder.pop_front(); y = gorder.pop_front();
    chk(x == a, "R8", "first grant", x, a);
    chk(y == b, "R8", "second grant", y, b);
  endtask

  initial begin
    for (int j = 0; j < NC; j++) for (int l = 0; l < NL; l++) mst[j][l] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0 && grant == 0, "R1", "idle after reset", rsp_valid, 0);
    for (int l = 0; l < NL; l += 5) begin
      probe_line = l[LB-1:0]; #1;
      chk(probe_state == '0, "R1", "reset state", probe_state, 0);
    end
    access(0, 0, 32'h0000_0040);   // R4 read miss, alone -> EX
    access(0, 0, 32'h0000_0044);   // R3 read hit, same line
    access(0, 1, 32'h0000_0040);   // R7 write hit on EX
    access(1, 0, 32'h0000_0040);   // R5 read miss, core0 downgraded
    access(2, 0, 32'h0000_007F);   // R5 RO sharers, no downgrade; R2 alias
    access(2, 0, 32'h0000_0041);   // R3 read hit on RO
    access(1, 1, 32'h0000_0040);   // R6 write on RO, inval 0 and 2
    access(3, 1, 32'h0000_0050);   // R6 write miss, inval core1
    access(3, 1, 32'h0000_007C);   // R7 write hit via alias
    access(0, 1, 32'h0000_0080);   // R6 write miss, no holders
    access(2, 0, 32'h0000_00BF);   // R5 downgrade core0, other line
    gorder.delete();
    fork                            // R8 rotation from last=2
      access(0, 0, 32'h0000_0100);
      access(1, 0, 32'h0000_0140);
      access(2, 0, 32'h0000_0180);
      access(3, 0, 32'h0000_01C0);
    join
    begin
      int a[4];
      for (int i = 0; i < 4; i++) a[i] = gorder.pop_front();
      chk(a[0] == 3 && a[1] == 0 && a[2] == 1 && a[3] == 2, "R8", "rotation",
          a[0]*1000 + a[1]*100 + a[2]*10 + a[3], 3012);
    end
    fork access(0, 1, 32'h0000_0100); access(2, 1, 32'h0000_0100); join
    chk_order(0, 2);                // R8 last=2 -> 3 skipped, 0 then 2
    fork access(1, 0, 32'h0000_0100); access(3, 0, 32'h0000_0100); join
    chk_order(3, 1);                // R8 last=2 -> 3 then 1
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "pending responses", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    while (!done && cycles < 20000) begin @(posedge clk); cycles++; end
    if (!done) chk(0, "R9", "watchdog", cycles, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule